// File: doc/BRIEF.md
# Tagged UART Receive FIFO

This block sits between a serial receiver's shift stage and the host's register strobes. Each time the shift stage finishes a character it presents the character with three line flags: parity error, framing error and break. The block stores the character and its flags as one FIFO entry. When the host reads, it gets a 16-bit word that carries the oldest character in the low bits and that character's own status in the upper bits. Because the status travels with each entry, the host can tell exactly which character was damaged, even when it drains the queue long after the line event.

The host sees two fill indications. The first, data-ready, is set whenever anything is stored. The second, receiver-ready, is set only once the fill count reaches a programmable trigger level, so an interrupt or DMA request can be batched. Two sticky status bits record overrun and break, and each is cleared by writing a 1 to its mask position. A receive-enable level input gates all line traffic. A soft-reset strobe empties the queue and clears the sticky bits.

All host-side controls are single-cycle strobes sampled on the rising clock edge. Read data and flags are registered, so they change on the edge that takes the strobe.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: The queue holds DEPTH (default 32, a power of two) entries. `fifo_full` is 1 exactly when DEPTH entries are stored, and `fifo_empty` is 1 exactly when none are stored.
- R2: The read word layout is as follows. Bit 15 is valid. Bit 14 is the error summary. Bit 13 is overrun. Bit 12 is framing error. Bit 11 is break. Bit 10 is parity error. Bits 9:8 are zero. Bits 7:0 are the character.
- R3: Bit 14 of every valid read word equals the OR of bits 13, 12, 11 and 10 of that same word.
- R4: `data_ready` is 1 exactly when at least one entry is stored.
- R5: `rx_ready` is 1 when the fill count is at least the 6-bit trigger level, where a level of 0 acts as 1. The level resets to 1 and is loaded from `lvl_wdata` on a `lvl_wr` strobe. Flags use the new level in the same edge that loads it.
- R6: A character that arrives while the queue is full, with no pop in the same cycle, is discarded. It sets `ovr_sticky` and marks overrun on the newest stored entry.
- R7: A `rd_pop` strobe on a non-empty queue removes the oldest entry, and the entry appears on `rd_word` after that edge. A pop on an empty queue makes `rd_word` all zeros and leaves the queue contents unchanged.
- R8: `brk_sticky` is set by any accepted-side character that arrives with break while reception is enabled. It is cleared by `clr_wr` with `clr_mask[1]`=1. A set in the same cycle wins over the clear.
- R9: `ovr_sticky` is cleared by `clr_wr` with `clr_mask[0]`=1. A clear with that bit at 0 leaves it unchanged.
- R10: While `rx_en` is 0, incoming characters are ignored: nothing is stored and no sticky bit is set.
- R11: A `soft_rst` strobe empties the queue, clears both sticky bits and the read word, and keeps the trigger level.
- R12: When a character arrives in the same cycle as a pop on a full queue, the character is stored and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable level |
| soft_rst | input | 1 | Strobe: flush queue and sticky status |
| ln_valid | input | 1 | Strobe: character assembled by the shift stage |
| ln_char | input | CHAR_W | Received character |
| ln_par_err | input | 1 | Parity error on this character |
| ln_frm_err | input | 1 | Framing error on this character |
| ln_brk | input | 1 | Break detected on this character |
| rd_pop | input | 1 | Strobe: read and remove oldest entry |
| rd_word | output | 16 | Tagged read word |
| lvl_wr | input | 1 | Strobe: load trigger level |
| lvl_wdata | input | LVL_W | New trigger level |
| clr_wr | input | 1 | Strobe: write-one-to-clear sticky bits |
| clr_mask | input | 2 | bit0 clears overrun, bit1 clears break |
| data_ready | output | 1 | At least one entry stored |
| rx_ready | output | 1 | Fill count has reached the trigger level |
| ovr_sticky | output | 1 | Overrun seen since last clear |
| brk_sticky | output | 1 | Break seen since last clear |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |

## Verification
The bench sweeps every trigger level from 0 to 63 at every fill count from empty to full. A design that treated level 0 literally, or that compared with a strict inequality, would raise `rx_ready` one entry early or one entry late. It fills the queue past capacity and then drains it. A design that overwrote the oldest entry, or that tagged the wrong entry, would return a mismatched character or misplaced bit 13. It also covers a pop on an empty queue followed by a push, a push and a pop together at full, ignored traffic with reception off, and a soft reset. A pointer that moves on an empty read, or a simultaneous push and pop treated as overrun, would show up there as wrong read data or a spurious `ovr_sticky`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_WORD_W  = 16;
  localparam int RXQ_VALID_B = 15;
  localparam int RXQ_ERR_B   = 14;
  localparam int RXQ_OVR_B   = 13;
  localparam int RXQ_FRM_B   = 12;
  localparam int RXQ_BRK_B   = 11;
  localparam int RXQ_PAR_B   = 10;
  localparam int RXQ_CHAR_MAX = 10;

  // line-side status stored next to each character
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 32,
  parameter int CHAR_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int EW    = CHAR_W + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [CHAR_W-1:0]     wr_char,
  input  rxq_pkg::rxq_flags_t   wr_flags,
  input  logic                  mark_en,
  input  logic [AW-1:0]         mark_addr,
  input  logic                  pop_req,
  input  logic                  pop_ok,
  input  logic [AW-1:0]         rd_addr,
  output logic                  rd_valid,
  output logic                  rd_ovr,
  output logic [CHAR_W-1:0]     rd_char,
  output rxq_pkg::rxq_flags_t   rd_flags
);
  logic [EW-1:0]    mem [DEPTH];
  logic [EW-1:0]    rd_q;
  logic [DEPTH-1:0] ovr_mark_q;
  logic             rd_ovr_q;
  logic             rd_valid_q;

  // plain dual-port array, read-first, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_flags, wr_char};
    if (pop_ok) rd_q <= mem[rd_addr];
  end

  // overrun tags live in flops so the newest entry can be marked in place
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ovr_mark_q <= '0;
      rd_ovr_q   <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      if (wr_en)   ovr_mark_q[wr_addr]   <= 1'b0;
      if (mark_en) ovr_mark_q[mark_addr] <= 1'b1;
      if (pop_ok)  rd_ovr_q <= ovr_mark_q[rd_addr];
      if (pop_req) rd_valid_q <= pop_ok;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_ovr   = rd_ovr_q;
  assign rd_char  = rd_q[CHAR_W-1:0];
  assign rd_flags = rxq_pkg::rxq_flags_t'(rd_q[EW-1:CHAR_W]);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int KW   = (CW > LVL_W) ? CW : LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             lvl_wr,
  input  logic [LVL_W-1:0] lvl_wdata,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [AW-1:0]    last_ptr,
  output logic             full,
  output logic             empty,
  output logic             avail,
  output logic             ready
);
  logic [CW-1:0]    count_q, count_nxt;
  logic [LVL_W-1:0] lvl_q, lvl_nxt;
  logic [AW-1:0]    wr_q, rd_q;
  logic             full_q, empty_q, avail_q, ready_q;
  logic             is_full, is_empty;
  logic [KW-1:0]    cnt_k, lvl_k;

  assign is_full  = (count_q == CW'(DEPTH));
  assign is_empty = (count_q == '0);
  assign pop_ok   = pop_req && !is_empty && !flush;
  assign push_ok  = push_req && !flush && (!is_full || pop_ok);
  assign drop     = push_req && !flush && is_full && !pop_ok;

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count_q + CW'(push_ok) - CW'(pop_ok);
    lvl_nxt = lvl_wr ? lvl_wdata : lvl_q;
    cnt_k   = KW'(count_nxt);
    lvl_k   = (lvl_nxt == '0) ? KW'(1) : KW'(lvl_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      lvl_q   <= LVL_W'(1);
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      avail_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (flush) begin
        wr_q <= '0;
        rd_q <= '0;
      end else begin
        if (push_ok) wr_q <= wr_q + 1'b1;
        if (pop_ok)  rd_q <= rd_q + 1'b1;
      end
      count_q <= count_nxt;
      lvl_q   <= lvl_nxt;
      full_q  <= (count_nxt == CW'(DEPTH));
      empty_q <= (count_nxt == '0);
      avail_q <= (count_nxt != '0);
      ready_q <= (cnt_k >= lvl_k);
    end
  end

  assign wr_ptr   = wr_q;
  assign rd_ptr   = rd_q;
  assign last_ptr = wr_q - 1'b1;
  assign full     = full_q;
  assign empty    = empty_q;
  assign avail    = avail_q;
  assign ready    = ready_q;
endmodule

// File: rtl/rxq_status.sv
module rxq_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       set_ovr,
  input  logic       set_brk,
  input  logic       clr_wr,
  input  logic [1:0] clr_mask,
  output logic       ovr,
  output logic       brk
);
  logic ovr_q, brk_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      if (set_ovr)                      ovr_q <= 1'b1;
      else if (clr_wr && clr_mask[0])   ovr_q <= 1'b0;
      if (set_brk)                      brk_q <= 1'b1;
      else if (clr_wr && clr_mask[1])   brk_q <= 1'b0;
    end
  end

  assign ovr = ovr_q;
  assign brk = brk_q;
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo #(
  parameter int DEPTH  = 32,
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 6,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              ln_valid,
  input  logic [CHAR_W-1:0] ln_char,
  input  logic              ln_par_err,
  input  logic              ln_frm_err,
  input  logic              ln_brk,
  input  logic              rd_pop,
  output logic [15:0]       rd_word,
  input  logic              lvl_wr,
  input  logic [LVL_W-1:0]  lvl_wdata,
  input  logic              clr_wr,
  input  logic [1:0]        clr_mask,
  output logic              data_ready,
  output logic              rx_ready,
  output logic              ovr_sticky,
  output logic              brk_sticky,
  output logic              fifo_full,
  output logic              fifo_empty
);
  import rxq_pkg::*;

  logic                push_req, push_ok, pop_ok, drop;
  logic [AW-1:0]       wr_ptr, rd_ptr, last_ptr;
  logic                rd_valid, rd_ovr;
  logic [CHAR_W-1:0]   rd_char;
  rxq_flags_t          in_flags, rd_flags;

  assign push_req = ln_valid && rx_en;
  assign in_flags = '{brk: ln_brk, frm: ln_frm_err, par: ln_par_err};

  rxq_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) ctrl_i (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .push_req(push_req), .pop_req(rd_pop),
    .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .push_ok(push_ok), .pop_ok(pop_ok), .drop(drop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .last_ptr(last_ptr),
    .full(fifo_full), .empty(fifo_empty),
    .avail(data_ready), .ready(rx_ready)
  );

  rxq_store #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) store_i (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .wr_en(push_ok), .wr_addr(wr_ptr),
    .wr_char(ln_char), .wr_flags(in_flags),
    .mark_en(drop), .mark_addr(last_ptr),
    .pop_req(rd_pop), .pop_ok(pop_ok), .rd_addr(rd_ptr),
    .rd_valid(rd_valid), .rd_ovr(rd_ovr),
    .rd_char(rd_char), .rd_flags(rd_flags)
  );

  rxq_status status_i (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .set_ovr(drop), .set_brk(push_req && ln_brk && !soft_rst),
    .clr_wr(clr_wr), .clr_mask(clr_mask),
    .ovr(ovr_sticky), .brk(brk_sticky)
  );

  // tagged word assembly; fields are forced to zero on an empty read
  always_comb begin
    rd_word = '0;
    if (rd_valid) begin
      rd_word[RXQ_VALID_B] = 1'b1;
      rd_word[RXQ_OVR_B]   = rd_ovr;
      rd_word[RXQ_FRM_B]   = rd_flags.frm;
      rd_word[RXQ_BRK_B]   = rd_flags.brk;
      rd_word[RXQ_PAR_B]   = rd_flags.par;
      rd_word[RXQ_ERR_B]   = rd_ovr | rd_flags.frm | rd_flags.brk | rd_flags.par;
      rd_word[CHAR_W-1:0]  = rd_char;
    end
  end
endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
module rxq_tagged_fifo_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_en,
  input logic        soft_rst,
  input logic        ln_valid,
  input logic        ln_brk,
  input logic        rd_pop,
  input logic [15:0] rd_word,
  input logic        data_ready,
  input logic        rx_ready,
  input logic        ovr_sticky,
  input logic        brk_sticky,
  input logic        fifo_full,
  input logic        fifo_empty
);
  // R1: full and empty are never reported together
  p_full_empty_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  // R4: an empty queue never reports data present
  p_empty_no_data_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !data_ready);

  // R5: threshold flag implies at least one entry
  p_ready_has_data_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> data_ready);

  // R6: arrival on a full queue without a pop sets overrun
  p_ovr_on_full_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && ln_valid && rx_en && !rd_pop && !soft_rst) |=> ovr_sticky);

  // R7: reading an empty queue returns an all-zero word
  p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && rd_pop && !soft_rst) |=> (rd_word == 16'h0000));

  // R8: break on an enabled arrival sets the sticky bit
  p_brk_set_r8: assert property (@(posedge clk) disable iff (rst)
    (ln_valid && rx_en && ln_brk && !soft_rst) |=> brk_sticky);

  // R10: with reception off, an empty queue stays empty
  p_rx_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && fifo_empty && !soft_rst) |=> fifo_empty);

  // R11: soft reset empties and clears sticky status
  p_soft_rst_r11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (fifo_empty && !ovr_sticky && !brk_sticky));
endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk chk_i (
  .clk(clk), .rst(rst), .rx_en(rx_en), .soft_rst(soft_rst),
  .ln_valid(ln_valid), .ln_brk(ln_brk), .rd_pop(rd_pop), .rd_word(rd_word),
  .data_ready(data_ready), .rx_ready(rx_ready),
  .ovr_sticky(ovr_sticky), .brk_sticky(brk_sticky),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/rxq_tagged_fifo_tb_top.sv
module rxq_tagged_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b1, soft_rst = 1'b0, ln_valid = 1'b0;
  logic [7:0] ln_char = '0;
  logic       ln_par_err = 1'b0, ln_frm_err = 1'b0, ln_brk = 1'b0;
  logic       rd_pop = 1'b0, lvl_wr = 1'b0, clr_wr = 1'b0;
  logic [5:0] lvl_wdata = '0;
  logic [1:0] clr_mask = '0;
  logic [15:0] rd_word;
  logic data_ready, rx_ready, ovr_sticky, brk_sticky, fifo_full, fifo_empty;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mq[$];
  bit   m_ovr = 0, m_brk = 0;
  int   m_lvl = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_tagged_fifo dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .soft_rst(soft_rst),
    .ln_valid(ln_valid), .ln_char(ln_char), .ln_par_err(ln_par_err),
    .ln_frm_err(ln_frm_err), .ln_brk(ln_brk), .rd_pop(rd_pop),
    .rd_word(rd_word), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .data_ready(data_ready),
    .rx_ready(rx_ready), .ovr_sticky(ovr_sticky), .brk_sticky(brk_sticky),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(logic [7:0] c, bit pe, bit fe, bit bk);
    logic [15:0] w;
    w = {8'h80, c};
    w[12] = fe; w[11] = bk; w[10] = pe;
    w[14] = pe | fe | bk;
    return w;
  endfunction

  function automatic int eff_lvl();
    return (m_lvl == 0) ? 1 : m_lvl;
  endfunction

  task automatic chk_flags(string req);
    int n = mq.size();
    chk("R1", "fifo_full", fifo_full, n == DEPTH);
    chk("R1", "fifo_empty", fifo_empty, n == 0);
    chk("R4", "data_ready", data_ready, n > 0);
    chk(req, "rx_ready", rx_ready, n >= eff_lvl());
    chk("R9", "ovr_sticky", ovr_sticky, m_ovr);
    chk("R8", "brk_sticky", brk_sticky, m_brk);
  endtask

  // one-cycle character arrival; model updated from the requirements
  task automatic push(logic [7:0] c, bit pe, bit fe, bit bk);
    ln_valid = 1'b1; ln_char = c; ln_par_err = pe; ln_frm_err = fe; ln_brk = bk;
    @(negedge clk);
    ln_valid = 1'b0; ln_par_err = 1'b0; ln_frm_err = 1'b0; ln_brk = 1'b0;
    if (rx_en) begin
      if (bk) m_brk = 1;
      if (mq.size() < DEPTH) mq.push_back(mk_word(c, pe, fe, bk));
      else begin
        m_ovr = 1;
        mq[mq.size()-1] = mq[mq.size()-1] | 16'h6000;
      end
    end
  endtask

  task automatic pop(string req);
    logic [15:0] exp;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    exp = (mq.size() > 0) ? mq.pop_front() : 16'h0000;
    chk(req, "rd_word", rd_word, exp);
  endtask

  task automatic set_lvl(int l);
    lvl_wr = 1'b1; lvl_wdata = 6'(l);
    @(negedge clk);
    lvl_wr = 1'b0;
    m_lvl = l;
  endtask

  task automatic clear(logic [1:0] m);
    clr_wr = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_wr = 1'b0; clr_mask = '0;
    if (m[0]) m_ovr = 0;
    if (m[1]) m_brk = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, default level 1 (R5)
    chk("R7", "rd_word reset", rd_word, 16'h0);
    chk_flags("R5");

    // R7: empty read, then a push must land at the unchanged head
    pop("R7");
    chk_flags("R7");
    push(8'hA5, 0, 0, 0);
    chk_flags("R5");
    pop("R7");
    chk_flags("R4");

    // R5: sweep every level at every fill count
    for (int c = 0; c <= DEPTH; c++) begin
      for (int l = 0; l < 64; l++) begin
        set_lvl(l);
        chk("R5", "rx_ready sweep", rx_ready, c >= eff_lvl());
      end
      if (c < DEPTH)
        push(8'(c * 7 + 3), c[0], c[1], (c % 5) == 0);
    end
    set_lvl(1);
    chk_flags("R1");

    // R6: overrun on full, newest entry tagged, char dropped
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    chk_flags("R6");
    chk("R6", "ovr_sticky", ovr_sticky, 1'b1);

    // R12: push with pop at full accepted, no new overrun
    clear(2'b01);
    chk("R9", "ovr cleared", ovr_sticky, 1'b0);
    chk("R8", "brk kept on ovr clear", brk_sticky, 1'b1);
    begin
      logic [15:0] exp;
      ln_valid = 1'b1; ln_char = 8'h5C; rd_pop = 1'b1;
      @(negedge clk);
      ln_valid = 1'b0; rd_pop = 1'b0;
      exp = mq.pop_front();
      mq.push_back(mk_word(8'h5C, 0, 0, 0));
      chk("R12", "rd_word", rd_word, exp);
      chk("R12", "no overrun", ovr_sticky, 1'b0);
      chk("R12", "still full", fifo_full, 1'b1);
    end

    // R2/R3: drain and compare each tagged word
    while (mq.size() > 0) begin
      pop("R2");
      chk("R3", "err summary", rd_word[14], |rd_word[13:10]);
    end
    chk_flags("R4");

    // R8: break sticky, clear, set wins over clear
    clear(2'b10);
    chk("R8", "brk cleared", brk_sticky, 1'b0);
    ln_valid = 1'b1; ln_char = 8'h00; ln_brk = 1'b1; clr_wr = 1'b1; clr_mask = 2'b10;
    @(negedge clk);
    ln_valid = 1'b0; ln_brk = 1'b0; clr_wr = 1'b0; clr_mask = '0;
    mq.push_back(mk_word(8'h00, 0, 0, 1)); m_brk = 1;
    chk("R8", "set wins", brk_sticky, 1'b1);
    pop("R8");
    clear(2'b10);

    // R10: reception disabled ignores characters
    rx_en = 1'b0;
    push(8'h11, 1'b1, 1'b1, 1'b1);
    push(8'h22, 1'b0, 1'b0, 1'b1);
    chk_flags("R10");
    chk("R10", "brk untouched", brk_sticky, 1'b0);
    pop("R10");
    rx_en = 1'b1;

    // R11: soft reset flushes, clears sticky, keeps level
    set_lvl(3);
    for (int i = 0; i <= DEPTH; i++) push(8'(i), 0, 0, 1);
    chk_flags("R6");
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    mq.delete(); m_ovr = 0; m_brk = 0;
    chk_flags("R11");
    chk("R11", "rd_word", rd_word, 16'h0);
    push(8'h31, 0, 0, 0);
    push(8'h32, 0, 0, 0);
    chk("R11", "level kept (2<3)", rx_ready, 1'b0);
    push(8'h33, 0, 1, 0);
    chk("R11", "level kept (3>=3)", rx_ready, 1'b1);
    pop("R11"); pop("R11"); pop("R3");
    chk_flags("R4");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule